// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block produces the message-passing interrupts for a memory shared by two ports. It watches the address and the active-low chip-select, write-enable and output-enable strobes of each port on every clock. Two word addresses at the very top of the address space serve as mailboxes. The all-ones address belongs to port 1. The address one below it belongs to port 0.

When a port writes the mailbox that belongs to the opposite port, the block pulls the owner's active-low interrupt output low. The owner acknowledges the message by reading its own mailbox, and that read returns its interrupt output high. The message word itself sits in the ordinary storage array next to this block. The controller never looks at the data bus.

A port writing its own mailbox, or reading the other port's mailbox, leaves both interrupts as they are. Accesses to any other address do the same. If a set and a clear of the same interrupt fall in the same cycle, the set wins, so a new message is never lost to an acknowledge of the previous one.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, both `p0_irq_n` and `p1_irq_n` are 1 (inactive).
- R2: A port 0 write (`p0_cs_n`=0, `p0_we_n`=0) to address all-ones drives `p1_irq_n` to 0 at the clock edge that samples the write.
- R3: A port 1 write (`p1_cs_n`=0, `p1_we_n`=0) to address all-ones minus one drives `p0_irq_n` to 0 at the clock edge that samples the write.
- R4: A port 1 read (`p1_cs_n`=0, `p1_we_n`=1, `p1_oe_n`=0) of address all-ones returns `p1_irq_n` to 1 at the clock edge that samples the read.
- R5: A port 0 read (`p0_cs_n`=0, `p0_we_n`=1, `p0_oe_n`=0) of address all-ones minus one returns `p0_irq_n` to 1 at the clock edge that samples the read.
- R6: An access with chip select high does not count as a read or a write. A cycle with chip select low and both write enable and output enable high does not count as a read, so it clears no interrupt.
- R7: A port writing its own mailbox, or reading the opposite port's mailbox, changes neither interrupt output.
- R8: When the set and the clear of one interrupt occur in the same cycle, the interrupt output ends that cycle at 0.
- R9: Accesses to any address other than the two mailboxes change neither interrupt output.
- R10: With no set or clear event for it, an interrupt output holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_cs_n | input | 1 | Port 0 chip select, active low |
| p0_we_n | input | 1 | Port 0 write enable, active low |
| p0_oe_n | input | 1 | Port 0 output enable, active low |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_cs_n | input | 1 | Port 1 chip select, active low |
| p1_we_n | input | 1 | Port 1 write enable, active low |
| p1_oe_n | input | 1 | Port 1 output enable, active low |
| p0_irq_n | output | 1 | Interrupt to port 0, active low |
| p1_irq_n | output | 1 | Interrupt to port 1, active low |

## Verification
The bench builds the block with `ADDR_W` = 4, a space of only sixteen words. At that size, randomly drawn addresses land on the mailboxes and on their neighbours often, alongside the addresses the bench aims at the mailboxes on purpose. This brings within reach the same-cycle set and clear from both ports, own-mailbox writes and cross reads interleaved with real events, and near-miss addresses one step away from a mailbox. Directed sequences cover the strobe combinations that must not count as a read or a write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Events decoded from one port's strobes in one cycle
  typedef struct packed {
    logic wr_peer;  // write to the opposite port's mailbox
    logic rd_own;   // read of this port's own mailbox
  } mbx_evt_t;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] OWN_ADDR  = '1,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  output mbx_evt_t          evt
);

  logic wr_cyc;
  logic rd_cyc;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    wr_cyc   = !cs_n && !we_n;
    rd_cyc   = !cs_n &&  we_n && !oe_n;
    hit_own  = (addr == OWN_ADDR);
    hit_peer = (addr == PEER_ADDR);
    evt.wr_peer = wr_cyc && hit_peer;
    evt.rd_own  = rd_cyc && hit_own;
  end

  // R6: a single port never reads and writes in the same cycle
  p_evt_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.wr_peer, evt.rd_own}));

  // R6: nothing is decoded while the port is deselected
  p_cs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (evt == '0));

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);

  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = set_i || clr_i;
    pend_d  = set_i;  // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_n = !pend_q;

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n);

  p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> !irq_n);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_cs_n,
  input  logic              p0_we_n,
  input  logic              p0_oe_n,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_cs_n,
  input  logic              p1_we_n,
  input  logic              p1_oe_n,
  output logic              p0_irq_n,
  output logic              p1_irq_n
);

  localparam int unsigned NPORT = 2;
  localparam logic [ADDR_W-1:0] P1_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] P0_BOX = P1_BOX - 1'b1;

  logic rst_int_n;

  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [NPORT-1:0]  cs_v, we_v, oe_v, irq_v;
  mbx_evt_t          evt_v  [NPORT];

  always_comb begin
    addr_v[0] = p0_addr;  addr_v[1] = p1_addr;
    cs_v = {p1_cs_n, p0_cs_n};
    we_v = {p1_we_n, p0_we_n};
    oe_v = {p1_oe_n, p0_oe_n};
  end

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (g == 0) ? P0_BOX : P1_BOX;
    localparam logic [ADDR_W-1:0] PEER = (g == 0) ? P1_BOX : P0_BOX;

    mbx_port_decode #(
      .ADDR_W    (ADDR_W),
      .OWN_ADDR  (OWN),
      .PEER_ADDR (PEER)
    ) u_dec (
      .clk  (clk),
      .rst_n(rst_int_n),
      .addr (addr_v[g]),
      .cs_n (cs_v[g]),
      .we_n (we_v[g]),
      .oe_n (oe_v[g]),
      .evt  (evt_v[g])
    );

    // interrupt g is set by the other port, cleared by its owner
    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_int_n),
      .set_i (evt_v[NPORT-1-g].wr_peer),
      .clr_i (evt_v[g].rd_own),
      .irq_n (irq_v[g])
    );
  end

  assign p0_irq_n = irq_v[0];
  assign p1_irq_n = irq_v[1];

  // R9: with no mailbox address on either bus, both outputs hold
  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (p0_addr != P0_BOX && p0_addr != P1_BOX &&
     p1_addr != P0_BOX && p1_addr != P1_BOX)
    |=> ($stable(p0_irq_n) && $stable(p1_irq_n)));

  // R7: port 0 writing its own box while port 1 stays off the bus leaves both alone
  p_own_write_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!p0_cs_n && !p0_we_n && p0_addr == P0_BOX && p1_cs_n)
    |=> ($stable(p0_irq_n) && $stable(p1_irq_n)));

endmodule

// File: tb/sim_mbx_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_irq_ctrl;

  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] BOX1 = {AW{1'b1}};
  localparam logic [AW-1:0] BOX0 = BOX1 - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a0 = '0, a1 = '0;
  logic cs0 = 1, we0 = 1, oe0 = 1, cs1 = 1, we1 = 1, oe1 = 1;
  logic irq0_n, irq1_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic m0 = 0, m1 = 0;  // model: interrupt pending

  always #10 clk = ~clk;  // 50 MHz

  mbx_irq_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .p0_addr(a0), .p0_cs_n(cs0), .p0_we_n(we0), .p0_oe_n(oe0),
    .p1_addr(a1), .p1_cs_n(cs1), .p1_we_n(we1), .p1_oe_n(oe1),
    .p0_irq_n(irq0_n), .p1_irq_n(irq1_n)
  );

  function automatic logic is_wr(logic cs, logic we);
    return !cs && !we;
  endfunction

  function automatic logic is_rd(logic cs, logic we, logic oe);
    return !cs && we && !oe;
  endfunction

  function automatic logic next_pend(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, check at the next negedge
  task automatic cyc(string req,
                     logic [AW-1:0] x0, logic c0, logic w0, logic o0,
                     logic [AW-1:0] x1, logic c1, logic w1, logic o1);
    logic s0, s1, k0, k1;
    a0 = x0; cs0 = c0; we0 = w0; oe0 = o0;
    a1 = x1; cs1 = c1; we1 = w1; oe1 = o1;
    s1 = is_wr(c0, w0) && x0 == BOX1;
    s0 = is_wr(c1, w1) && x1 == BOX0;
    k0 = is_rd(c0, w0, o0) && x0 == BOX0;
    k1 = is_rd(c1, w1, o1) && x1 == BOX1;
    m0 = next_pend(m0, s0, k0);
    m1 = next_pend(m1, s1, k1);
    @(posedge clk);
    @(negedge clk);
    check({req, " p0_irq_n"}, irq0_n, !m0);
    check({req, " p1_irq_n"}, irq1_n, !m1);
  endtask

  task automatic idle(string req);
    cyc(req, '0, 1, 1, 1, '0, 1, 1, 1);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int unsigned r = $urandom % 5;
    if (r == 0) return BOX1;
    if (r == 1) return BOX0;
    if (r == 2) return BOX0 - 1'b1;
    return AW'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 in reset p0_irq_n", irq0_n, 1'b1);
    check("R1 in reset p1_irq_n", irq1_n, 1'b1);
    rst_n = 1'b1;
    idle("R1");
    idle("R1");
    idle("R1");

    // R2 / R4: p0 posts to p1, p1 acknowledges
    cyc("R2", BOX1, 0, 0, 1, '0, 1, 1, 1);
    idle("R10");
    cyc("R4", '0, 1, 1, 1, BOX1, 0, 1, 0);
    // R3 / R5
    cyc("R3", '0, 1, 1, 1, BOX0, 0, 0, 1);
    cyc("R5", BOX0, 0, 1, 0, '0, 1, 1, 1);
    // R6: deselected write, and a read without output enable
    cyc("R6 cs high", BOX1, 1, 0, 1, BOX0, 1, 0, 1);
    cyc("R2", BOX1, 0, 0, 1, '0, 1, 1, 1);
    cyc("R6 oe high", '0, 1, 1, 1, BOX1, 0, 1, 1);
    cyc("R6 cs high read", '0, 1, 1, 1, BOX1, 1, 1, 0);
    // R7: own write, cross read
    cyc("R7 own write", '0, 1, 1, 1, BOX1, 0, 0, 1);
    cyc("R7 cross read", BOX1, 0, 1, 0, '0, 1, 1, 1);
    // R8: set and clear of p1 irq together
    cyc("R8", BOX1, 0, 0, 1, BOX1, 0, 1, 0);
    // R9: neighbour addresses
    cyc("R9", BOX0 - 1'b1, 0, 0, 1, BOX0 - 1'b1, 0, 1, 0);
    cyc("R4", '0, 1, 1, 1, BOX1, 0, 1, 0);
    // R8 for p0
    cyc("R3", '0, 1, 1, 1, BOX0, 0, 0, 1);
    cyc("R8", BOX0, 0, 1, 0, BOX0, 0, 0, 1);
    cyc("R5", BOX0, 0, 1, 0, '0, 1, 1, 1);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      cyc("R2-R10 random",
          pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom),
          pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // reset again mid-traffic
    cyc("R2", BOX1, 0, 0, 1, BOX0, 0, 0, 1);
    rst_n = 1'b0;
    m0 = 0; m1 = 0;
    #1;
    check("R1 async reset p0_irq_n", irq0_n, 1'b1);
    check("R1 async reset p1_irq_n", irq1_n, 1'b1);
    done = 1;
  end

  initial begin
    int unsigned n = 0;
    while (!done && n < 50000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule